// File: doc/BRIEF.md
# Order-Compatible Log-Space Score Accumulator

This block totals the local scores of one network node over the node's candidate parent sets. It only counts the sets that fit a proposed node ordering. Each candidate is a bitmask over the network's nodes and is stored in an external on-chip memory. Each candidate has one signed Q16.16 log-domain score, held in a second memory at the same address. The ordering arrives as a predecessor mask: a set bit means that node comes before this node.

On an accepted start strobe the block does four things:
- It latches the predecessor mask and the number of candidates.
- It reads the candidates one per cycle through a shared read port with one-cycle latency.
- It keeps each set whose members are all predecessors.
- It merges each kept score into a running log-sum as max(a,b) plus a softplus correction, log(1+exp(-|a-b|)), taken from a computed table.

A done pulse marks the moment the total is final. The total then stays on the output until the next accepted start. An ordering sampler can call the block once per node and proposal, then add the per-node totals for its acceptance test.

Top module: `order_score_acc`

## Requirements
- R1: Candidate i is compatible when (mask_i AND NOT pred_mask) equals zero. Bit j of a mask stands for node j.
- R2: An incompatible candidate leaves the running total unchanged.
- R3: An accepted start sets the total to the sentinel 0x80000000, the most negative Q16.16 value. The first compatible score then replaces the sentinel outright.
- R4: Later compatible scores s merge with the total t as max(t,s) + T[k]. Here d = max − min, k = floor(d / 2^13), so table steps are 1/8. T[k] = floor(ln(1+exp(−k/8)) · 2^16).
- R5: When k is 64 or more (difference of at least 8.0), the correction is zero and the total becomes max(t,s).
- R6: A merged total is clamped to 0x7FFFFFFF. It never falls below the larger of its two operands.
- R7: Starting in the cycle after the start edge, rd_en is high for set_count consecutive cycles. During those cycles rd_addr steps 0,1,…,set_count−1. mask_rdata and score_rdata are expected to carry entry a in the cycle after rd_addr=a.
- R8: done is a one-cycle pulse. It is registered on the (set_count+1)-th rising edge after the edge that samples start, including set_count = 0.
- R9: When no candidate is compatible, or set_count is 0, result equals 0x80000000 while done is high.
- R10: A start that arrives while a run is in progress is ignored. It has no effect on the result of the run.
- R11: After reset, done and rd_en are low and result is 0x80000000. result keeps its final value after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; ignored while busy |
| pred_mask | input | NODES (8) | Nodes ahead of this node in the ordering |
| set_count | input | $clog2(MAX_SETS+1) (4) | Number of candidates for this node |
| rd_en | output | 1 | Read strobe for mask and score memories |
| rd_addr | output | $clog2(MAX_SETS) (4) | Candidate address |
| mask_rdata | input | NODES (8) | Parent mask, one cycle after address |
| score_rdata | input | 32 | Q16.16 local score, one cycle after address |
| result | output | 32 | Accumulated Q16.16 log score |
| done | output | 1 | One-cycle pulse when result is final |

## Verification
The embedded properties assume three things about the inputs:
- set_count never exceeds MAX_SETS.
- The memories return valid data exactly one cycle after each read strobe.
- A start strobe is held for a single cycle.

The bench stays inside these assumptions. It uses counts of 0 to 10 and models the memories as registers that load on rd_en. It drives start at the falling edge for one cycle only, including the deliberate start issued during a run. Score patterns are chosen to reach the equal-score, wide-gap, saturation and all-negative corners as well as random sparse masks.

// File: rtl/order_score_acc.sv
module order_score_acc #(
  parameter int NODES     = 8,
  parameter int MAX_SETS  = 10,
  parameter int SW        = 32,
  parameter int FRAC      = 16,
  parameter int STEP_LOG2 = 3,
  parameter int LUT_BITS  = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [NODES-1:0]                pred_mask,
  input  logic [$clog2(MAX_SETS+1)-1:0]   set_count,
  output logic                            rd_en,
  output logic [$clog2(MAX_SETS)-1:0]     rd_addr,
  input  logic [NODES-1:0]                mask_rdata,
  input  logic [SW-1:0]                   score_rdata,
  output logic [SW-1:0]                   result,
  output logic                            done
);
  localparam int AW     = $clog2(MAX_SETS);
  localparam int CW     = $clog2(MAX_SETS + 1);
  localparam int LUT_N  = 1 << LUT_BITS;
  localparam int SHIFT  = FRAC - STEP_LOG2;
  localparam logic [SW-1:0] SENT = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [SW:0] MAXV = {2'b00, {(SW-1){1'b1}}};

  function automatic logic [SW-1:0] softplus_q(int k);
    real x;
    x = -real'(k) / real'(1 << STEP_LOG2);
    return SW'($rtoi($ln(1.0 + $exp(x)) * real'(1 << FRAC)));
  endfunction

  logic [SW-1:0] lut [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    localparam logic [SW-1:0] LV = softplus_q(k);
    assign lut[k] = LV;
  end

  logic [NODES-1:0] pred;
  logic [CW-1:0]    cnt;
  logic             v1, l1, empty;
  logic [SW-1:0]    acc;

  wire busy     = rd_en | v1 | empty;
  wire accept   = start & ~busy;
  wire last_adr = rd_addr == AW'(cnt - CW'(1));
  wire compat   = (mask_rdata & ~pred) == '0;

  wire                 a_ge  = $signed(acc) >= $signed(score_rdata);
  wire [SW-1:0]        mx    = a_ge ? acc : score_rdata;
  wire [SW-1:0]        mn    = a_ge ? score_rdata : acc;
  wire signed [SW:0]   diff  = $signed({mx[SW-1], mx}) - $signed({mn[SW-1], mn});
  wire [SW:0]          idx_f = diff >>> SHIFT;
  wire                 in_rng = idx_f < (SW+1)'(LUT_N);
  wire [SW-1:0]        corr  = in_rng ? lut[idx_f[LUT_BITS-1:0]] : '0;
  wire signed [SW:0]   sum   = $signed({mx[SW-1], mx}) + $signed({1'b0, corr});
  wire [SW-1:0]        merged = (sum > MAXV) ? MAXV[SW-1:0] : sum[SW-1:0];

  assign result = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_addr <= '0;
      pred    <= '0;
      cnt     <= '0;
      v1      <= 1'b0;
      l1      <= 1'b0;
      empty   <= 1'b0;
      done    <= 1'b0;
      acc     <= SENT;
    end else begin
      done  <= (v1 & l1) | empty;
      empty <= accept & (set_count == '0);
      v1    <= rd_en;
      l1    <= rd_en & last_adr;
      if (accept) begin
        rd_en   <= set_count != '0;
        rd_addr <= '0;
        pred    <= pred_mask;
        cnt     <= set_count;
        acc     <= SENT;
      end else begin
        if (rd_en) begin
          if (last_adr) rd_en <= 1'b0;
          else          rd_addr <= rd_addr + AW'(1);
        end
        if (v1 && compat)
          acc <= (acc == SENT) ? score_rdata : merged;
      end
    end
  end

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (CW'(rd_addr) < cnt));
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !last_adr) |=> (rd_en && rd_addr == AW'($past(rd_addr) + AW'(1))));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);
  // R2
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !compat && !accept) |=> $stable(result));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && compat && !accept && acc != SENT) |=>
      ($signed(result) >= $signed($past(acc)) &&
       $signed(result) >= $signed($past(score_rdata))));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rd_en) |=> $stable(pred));
endmodule

// File: tb/order_score_acc_tb.sv
module order_score_acc_tb;
  localparam int NODES = 8;
  localparam int MAX_SETS = 10;
  localparam longint SENT = -64'sd2147483648;
  localparam longint MAXV = 64'sd2147483647;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NODES-1:0] pred_mask = '0;
  logic [3:0] set_count = '0;
  logic rd_en;
  logic [3:0] rd_addr;
  logic [NODES-1:0] mask_rdata;
  logic [31:0] score_rdata;
  logic [31:0] result;
  logic done;

  logic [NODES-1:0] mmask [MAX_SETS];
  logic [31:0]      mscore [MAX_SETS];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  order_score_acc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pred_mask(pred_mask),
    .set_count(set_count), .rd_en(rd_en), .rd_addr(rd_addr),
    .mask_rdata(mask_rdata), .score_rdata(score_rdata),
    .result(result), .done(done));

  always_ff @(posedge clk) begin
    if (rd_en) begin
      mask_rdata  <= mmask[rd_addr];
      score_rdata <= mscore[rd_addr];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp=<finish>", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint comb(input longint a, input longint b);
    longint mx, mn, d, k, s;
    if (a == SENT) return b;
    mx = (a >= b) ? a : b;
    mn = (a >= b) ? b : a;
    d = mx - mn;
    k = d / 8192;
    s = mx;
    if (k < 64) s = mx + longint'($rtoi($ln(1.0 + $exp(-real'(k) / 8.0)) * 65536.0));
    if (s > MAXV) s = MAXV;
    return s;
  endfunction

  task automatic run(input logic [NODES-1:0] pm, input int n, input int poke, input string tag);
    longint expv = SENT;
    for (int i = 0; i < n; i++)
      if ((mmask[i] & ~pm) == '0) expv = comb(expv, longint'($signed(mscore[i])));
    @(negedge clk);
    pred_mask = pm;
    set_count = 4'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n + 3; k++) begin
      @(negedge clk);
      check(done == (k == n + 1), {tag, " R8 done timing"}, longint'(done), longint'(k == n + 1));
      if (k >= n + 1)
        check(longint'($signed(result)) == expv, {tag, " R11 result"}, longint'($signed(result)), expv);
      if (k == poke) begin
        pred_mask = ~pm;
        set_count = 4'(MAX_SETS);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  task automatic fill(input logic [NODES-1:0] m, input longint s);
    for (int i = 0; i < MAX_SETS; i++) begin
      mmask[i] = m;
      mscore[i] = 32'(s);
    end
  endtask

  initial begin
    fill('0, 0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(done == 1'b0, "R11 done reset", longint'(done), 0);
    check(rd_en == 1'b0, "R11 rd_en reset", longint'(rd_en), 0);
    check(longint'($signed(result)) == SENT, "R11 result reset", longint'($signed(result)), SENT);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 single compatible score replaces sentinel
    fill(8'h03, -123456);
    run(8'h0F, 1, 0, "R3");
    // R8 R9 empty list
    run(8'hFF, 0, 0, "R9 empty");
    // R1 R9 nothing compatible
    fill(8'h80, 5000);
    run(8'h7F, 3, 0, "R1 R9 none");
    // R4 equal scores
    fill(8'h01, 65536);
    run(8'h01, 2, 0, "R4 equal");
    // R5 wide gap
    fill(8'h00, 0);
    mscore[0] = 32'(10 * 65536);
    mscore[1] = 32'(1 * 65536);
    mscore[2] = 32'(-20 * 65536);
    run(8'h00, 3, 0, "R5 gap");
    // R6 saturation
    fill(8'h00, 64'sh7FFF0000);
    run(8'h00, 4, 0, "R6 sat");
    // R4 negative scores, mixed fractions
    fill(8'h00, 0);
    for (int i = 0; i < MAX_SETS; i++) mscore[i] = 32'(-(i * 30000) - 70000);
    run(8'h00, MAX_SETS, 0, "R4 neg");
    // R2 R1 mixed compatibility
    for (int i = 0; i < MAX_SETS; i++) begin
      mmask[i] = 8'(1 << (i % 8));
      mscore[i] = 32'(i * 20000 - 90000);
    end
    run(8'h55, MAX_SETS, 0, "R2 mix");
    // R7 random sparse lists of many lengths
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < MAX_SETS; i++) begin
        mmask[i] = 8'($urandom & $urandom & $urandom);
        mscore[i] = 32'(longint'($urandom_range(0, 25 * 65536)) - 20 * 65536);
      end
      run(8'($urandom), t % (MAX_SETS + 1), 0, "R7 rand");
    end
    // R10 start during a run
    for (int i = 0; i < MAX_SETS; i++) begin
      mmask[i] = 8'(i);
      mscore[i] = 32'(i * 11111 - 40000);
    end
    run(8'h0F, MAX_SETS, 2, "R10 busy");
    run(8'h0F, MAX_SETS, 6, "R10 busy late");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule